// File: doc/BRIEF.md
# System configuration control registers

A memory-mapped bank of board configuration registers on a simple 32-bit register bus with a word address, a write enable, write data and a combinational read-data return. Writes take effect on the rising clock edge; reads return the addressed register in the same cycle. One general register drives a set of board LED outputs. A read-only identity word, fixed by a parameter, carries a part-number field. That field decides whether three optional registers exist and whether the switch register is visible.

The block also holds a parameterised array of oscillator-frequency words. Software cannot address them directly. It reaches them through an indirect channel made of a data-out word, a data-return word, a control word and a status word. Writing the control word with its start bit set performs the transfer at that clock edge. The transfer is checked first: it needs function code 1 and a device index below the oscillator count. Any other transfer reports an error in the status word and leaves all stored values untouched. A delay-line register accepts writes only in its top byte.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset these registers read zero: general 0x00, general 0x04, select 0x08, frequency 0x14, divider 0x18, return 0xA0, data-out 0xA4 and status 0xAC. Control 0xA8 reads 0x00100000, delay-line 0x100 reads 0xFFFF0001, and oscillator i holds its parameter reset value.
- R2: Registers 0x04 and 0xA4 read back the last value written to them. Offset 0xFFC returns the identity parameter, 0xFF8 returns the auxiliary identity parameter and 0x10 returns the board-info parameter. Writes to these three read-only offsets are ignored.
- R3: The select (0x08), frequency (0x14) and divider (0x18) registers are read/write only when identity bits [15:4] equal 0x524. On any other part they read zero and ignore writes.
- R4: The switch register at 0x0C always reads zero and ignores writes. On part 0x524 it is unmapped.
- R5: A read of any unmapped offset, including any address with bits [1:0] not zero, returns zero. A write to an unmapped offset changes no register.
- R6: A write to the delay-line register 0x100 replaces bits [31:24] only. Bits [23:0] keep their value.
- R7: From the cycle after a write to 0x00, LED output i equals bit i of the written data.
- R8: The control word (0xA8) has start at bit 31, write at bit 30, function code at bits [25:20] and device index at bits [11:0]. The status word (0xAC) has complete at bit 0 and error at bit 1. A control write with start=1, write=1, function 1 and device index below NUM_OSC copies the data-out word into that oscillator and sets status to 0x1.
- R9: A control write with start=1, write=0, function 1 and a valid device index loads that oscillator's value into the return word (0xA0) and sets status to 0x1.
- R10: A started transfer with a function code other than 1, or with a device index of NUM_OSC or more, sets status to 0x3. It changes neither the oscillators nor the return word.
- R11: The control word reads back the last written value with bit 31 cleared. A write to the status word replaces it with write-data bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| led | output | NUM_LED | LED drive, bits of general register 0x00 |

## Verification
The assertions take for granted that each bus write lasts one cycle and that address and data are stable across the sampling edge. They also assume a control write is judged on its own data, with no transfer still pending. The stimulus changes every bus input on the falling edge and holds bus_we high for exactly one rising edge per write. Reads are sampled only with bus_we low, so each check sees registered state alone. A second instance with part number 0x511 covers the gated offsets from the other side.

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs #(
  parameter int          NUM_OSC   = 3,
  parameter int          NUM_LED   = 2,
  parameter logic [31:0] ID_VAL    = 32'h4104_5240,
  parameter logic [31:0] AID_VAL   = 32'h0200_0008,
  parameter logic [31:0] INFO_VAL  = 32'h0000_0001,
  parameter logic [11:0] EXT_PART  = 12'h524,
  parameter logic [NUM_OSC*32-1:0] OSC_RESET = {32'd25000000, 32'd24576000, 32'd50000000}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_LED-1:0] led
);
  localparam logic [11:0] A_GEN0 = 12'h000, A_GEN1 = 12'h004, A_SEL = 12'h008,
                          A_SW = 12'h00C, A_INFO = 12'h010, A_FREQ = 12'h014,
                          A_DIV = 12'h018, A_RTN = 12'hA0, A_OUT = 12'hA4,
                          A_CTL = 12'hA8, A_STAT = 12'hAC, A_DLL = 12'h100,
                          A_AID = 12'hFF8, A_ID = 12'hFFC;
  localparam bit HAS_EXT = (ID_VAL[15:4] == EXT_PART);

  logic [31:0] gen0_q, gen1_q, sel_q, freq_q, div_q, rtn_q, out_q, ctl_q, dll_q;
  logic [1:0]  stat_q;
  logic [NUM_OSC-1:0][31:0] osc_q;
  logic [31:0] osc_rd;

  wire ctl_wr   = bus_we && bus_addr == A_CTL && bus_wdata[31];
  wire chan_ok  = bus_wdata[25:20] == 6'd1 && bus_wdata[11:0] < 12'(NUM_OSC);
  wire osc_we   = ctl_wr && chan_ok && bus_wdata[30];

  assign led = gen0_q[NUM_LED-1:0];

  always_comb begin
    osc_rd = '0;
    for (int i = 0; i < NUM_OSC; i++)
      if (bus_wdata[11:0] == 12'(i)) osc_rd = osc_q[i];
  end

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) osc_q[i] <= OSC_RESET[i*32 +: 32];
      else if (osc_we && bus_wdata[11:0] == 12'(i)) osc_q[i] <= out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen0_q <= '0; gen1_q <= '0; sel_q <= '0; freq_q <= '0; div_q <= '0;
      rtn_q  <= '0; out_q  <= '0; stat_q <= '0;
      ctl_q  <= 32'h0010_0000;
      dll_q  <= 32'hFFFF_0001;
    end else if (bus_we) begin
      case (bus_addr)
        A_GEN0: gen0_q <= bus_wdata;
        A_GEN1: gen1_q <= bus_wdata;
        A_SEL:  if (HAS_EXT) sel_q  <= bus_wdata;
        A_FREQ: if (HAS_EXT) freq_q <= bus_wdata;
        A_DIV:  if (HAS_EXT) div_q  <= bus_wdata;
        A_OUT:  out_q <= bus_wdata;
        A_STAT: stat_q <= bus_wdata[1:0];
        A_DLL:  dll_q[31:24] <= bus_wdata[31:24];
        A_CTL: begin
          ctl_q <= {1'b0, bus_wdata[30:0]};
          if (bus_wdata[31]) begin
            stat_q <= {~chan_ok, 1'b1};
            if (chan_ok && !bus_wdata[30]) rtn_q <= osc_rd;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_GEN0:  bus_rdata = gen0_q;
      A_GEN1:  bus_rdata = gen1_q;
      A_SEL:   bus_rdata = HAS_EXT ? sel_q  : '0;
      A_SW:    bus_rdata = '0;
      A_INFO:  bus_rdata = INFO_VAL;
      A_FREQ:  bus_rdata = HAS_EXT ? freq_q : '0;
      A_DIV:   bus_rdata = HAS_EXT ? div_q  : '0;
      A_RTN:   bus_rdata = rtn_q;
      A_OUT:   bus_rdata = out_q;
      A_CTL:   bus_rdata = ctl_q;
      A_STAT:  bus_rdata = {30'd0, stat_q};
      A_DLL:   bus_rdata = dll_q;
      A_AID:   bus_rdata = AID_VAL;
      A_ID:    bus_rdata = ID_VAL;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module sys_cfg_regs_chk #(
  parameter int NUM_LED = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_LED-1:0] led,
  input logic [31:0]        dll,
  input logic [1:0]         stat
);
  // R7
  led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h000) |=> led == $past(bus_wdata[NUM_LED-1:0]));
  // R6
  dll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dll[23:0]));
  // R8
  xfer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'hA8 && bus_wdata[31]) |=> stat[0]);
  // R10
  bad_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'hA8 && bus_wdata[31] && bus_wdata[25:20] != 6'd1) |=> stat == 2'b11);
  // R5
  misalign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);
endmodule

bind sys_cfg_regs sys_cfg_regs_chk #(.NUM_LED(NUM_LED)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led(led),
  .dll(dll_q), .stat(stat_q)
);

// File: tb/sys_cfg_regs_tb.sv
module sys_cfg_regs_tb_top;
  localparam logic [31:0] IDA = 32'h4104_5240;
  localparam logic [31:0] IDB = 32'h4104_5110;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,         12'h000, 32'h0,         8'd1},  // R1
    '{1'b0, 12'h000, 32'h0,         12'h0A8, 32'h0010_0000, 8'd1},  // R1
    '{1'b0, 12'h000, 32'h0,         12'h100, 32'hFFFF_0001, 8'd1},  // R1
    '{1'b0, 12'h000, 32'h0,         12'h0AC, 32'h0,         8'd1},  // R1
    '{1'b0, 12'h000, 32'h0,         12'hFFC, IDA,           8'd2},  // R2
    '{1'b1, 12'h004, 32'hA5A5_5A5A, 12'h004, 32'hA5A5_5A5A, 8'd2},  // R2
    '{1'b1, 12'h008, 32'h0000_1234, 12'h008, 32'h0000_1234, 8'd3},  // R3
    '{1'b1, 12'h014, 32'h017D_7840, 12'h014, 32'h017D_7840, 8'd3},  // R3
    '{1'b1, 12'h018, 32'h0000_0003, 12'h018, 32'h0000_0003, 8'd3},  // R3
    '{1'b1, 12'h00C, 32'h0000_FFFF, 12'h00C, 32'h0,         8'd4},  // R4
    '{1'b1, 12'h040, 32'hDEAD_BEEF, 12'h040, 32'h0,         8'd5},  // R5
    '{1'b1, 12'h100, 32'h1234_5678, 12'h100, 32'h12FF_0001, 8'd6},  // R6
    '{1'b1, 12'hFFC, 32'h0,         12'hFFC, IDA,           8'd2},  // R2
    '{1'b1, 12'h0A4, 32'h0BEB_C200, 12'h0A4, 32'h0BEB_C200, 8'd2},  // R2
    '{1'b1, 12'h0A8, 32'hC010_0001, 12'h0AC, 32'h1,         8'd8},  // R8
    '{1'b1, 12'h0A8, 32'h8010_0001, 12'h0A0, 32'h0BEB_C200, 8'd9},  // R9
    '{1'b1, 12'h0A8, 32'h8010_0000, 12'h0A0, 32'h02FA_F080, 8'd9},  // R9
    '{1'b1, 12'h0A8, 32'h8020_0000, 12'h0AC, 32'h3,         8'd10}, // R10
    '{1'b1, 12'h0A8, 32'h8010_0003, 12'h0A0, 32'h02FA_F080, 8'd10}, // R10
    '{1'b1, 12'h0AC, 32'h0,         12'h0AC, 32'h0,         8'd11}, // R11
    '{1'b1, 12'h0A8, 32'hC010_0005, 12'h0A8, 32'h4010_0005, 8'd11}, // R11
    '{1'b1, 12'h0A8, 32'h8010_0002, 12'h0A0, 32'h017D_7840, 8'd9}   // R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0, addr_b = '0;
  logic we = 1'b0, we_b = 1'b0;
  logic [31:0] wd = '0, wd_b = '0;
  logic [31:0] rd, rd_b;
  logic [1:0] led, led_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sys_cfg_regs #(.ID_VAL(IDA)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rd), .led(led));
  sys_cfg_regs #(.ID_VAL(IDB)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_b), .bus_we(we_b),
    .bus_wdata(wd_b), .bus_rdata(rd_b), .led(led_b));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input int req);
    @(negedge clk); addr = a; #1 check(rd, exp, req);
  endtask

  task automatic wr_b(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr_b = a; wd_b = d; we_b = 1'b1;
    @(negedge clk); we_b = 1'b0;
  endtask

  task automatic rd_b_chk(input logic [11:0] a, input logic [31:0] exp, input int req);
    @(negedge clk); addr_b = a; #1 check(rd_b, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].we) wr(VEC[k].addr, VEC[k].wd);
      rd_chk(VEC[k].ra, VEC[k].exp, int'(VEC[k].req));
    end
    // R7 LED outputs follow register 0x00
    wr(12'h000, 32'h0000_0003); #1 check({30'd0, led}, 32'h3, 7);
    wr(12'h000, 32'h0000_0002); #1 check({30'd0, led}, 32'h2, 7);
    // R2 info and auxiliary identity are fixed
    wr(12'h010, 32'hFFFF_FFFF); rd_chk(12'h010, 32'h1, 2);
    rd_chk(12'hFF8, 32'h0200_0008, 2);
    // R5 misaligned read
    rd_chk(12'h0A5, 32'h0, 5);
    // R3 R4 on part 0x511: gated offsets absent, switch register reads zero
    wr_b(12'h008, 32'h0000_1234); rd_b_chk(12'h008, 32'h0, 3);
    wr_b(12'h014, 32'h0000_5678); rd_b_chk(12'h014, 32'h0, 3);
    wr_b(12'h018, 32'h0000_0007); rd_b_chk(12'h018, 32'h0, 3);
    wr_b(12'h00C, 32'h0000_00FF); rd_b_chk(12'h00C, 32'h0, 4);
    // R10 invalid write transfer leaves oscillator 2 intact
    wr(12'h0A8, 32'hC010_0003);
    wr(12'h0A8, 32'h8010_0002); rd_chk(12'h0A0, 32'h017D_7840, 10);
    // R1 reset reloads oscillators and clears registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(12'h0A0, 32'h0, 1);
    rd_chk(12'h008, 32'h0, 1);
    #1 check({30'd0, led}, 32'h0, 1);
    wr(12'h0A8, 32'h8010_0001); rd_chk(12'h0A0, 32'h0177_0000, 1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule